// File: doc/BRIEF.md
# Host command vector interrupt register

This block is a 32-bit register through which a host processor raises a command interrupt in an embedded processor core. The host writes a 7-bit vector, a force-nonmaskable bit and a command bit in a single write. The core side sees one request line, the start address of the routine to run (twice the vector), a nonmaskable flag and a 2-bit priority level. The core acknowledges the request, and the command bit then clears.

A request that is not forced nonmaskable is gated by the local host-command interrupt enable and carries the programmed priority. A forced request bypasses both: it is issued at level 3 with the nonmaskable output raised. A vector of zero would point at the reset location, so a command write that carries vector zero is refused and flagged as an error. While a command is pending the register is frozen, so the vector cannot change under the core. The vector value loaded at reset comes from a configuration input.

Top module: `host_cmd_vec`

## Requirements
- R1: During and after reset the command bit (bit 0) and the nonmaskable bit (bit 15) read 0, the vector field reads the value on `cfg_vec_default`, `irq_req` and `irq_nmi` are 0, and `vec_err` is 0.
- R2: With the command bit clear, a host write loads `wr_data[7:1]` into the vector field and `wr_data[15]` into the nonmaskable bit, and these are visible on `rd_data` from the cycle after the write edge. The read format is {16'b0, nmi, 7'b0, vector[6:0], cmd}.
- R3: Bits 31 to 16 and 14 to 8 of `rd_data` always read 0, whatever data is written to them.
- R4: `irq_addr` always equals the current vector field times two, that is {vector, 1'b0}.
- R5: With the command and nonmaskable bits both set, `irq_req` and `irq_nmi` are 1 and `irq_level` is 3, whatever `hc_enable` and `prog_pri` hold.
- R6: With the command bit set and the nonmaskable bit clear, `irq_level` equals `prog_pri`, `irq_nmi` is 0, and `irq_req` equals `hc_enable`.
- R7: A write with `wr_data[0]`=1 and `wr_data[7:1]`=0, made while the command bit is clear, leaves the command bit at 0, raises no request and pulses `vec_err` high for exactly the following cycle. The vector field still takes the written value.
- R8: A write with `wr_data[0]`=1 and a nonzero vector sets the command bit. The bit stays set until `irq_ack` is high at a clock edge, and it reads 0 after that edge.
- R9: While the command bit is set, host writes change nothing: the vector, nonmaskable and command bits all keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_vec_default | input | 7 | Vector value loaded at reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 32 | Host write data |
| rd_data | output | 32 | Host read data, current register contents |
| hc_enable | input | 1 | Host-command interrupt enable |
| prog_pri | input | 2 | Programmed priority level |
| irq_req | output | 1 | Interrupt request to the core |
| irq_addr | output | 8 | Interrupt start address, vector times two |
| irq_nmi | output | 1 | Request is nonmaskable |
| irq_level | output | 2 | Priority level of the request |
| irq_ack | input | 1 | Core acknowledge |
| vec_err | output | 1 | One-cycle pulse after an illegal zero-vector command |

## Verification
Register state changes at the clock edge where the write or acknowledge is sampled. `rd_data`, `irq_addr` and `vec_err` are due in the half cycle that follows that edge. `irq_req`, `irq_nmi` and `irq_level` depend combinationally on the register state and on `hc_enable` and `prog_pri`, so they follow those inputs within the same cycle. The bench drives every input on the falling edge and updates its model at the next rising edge. It compares all outputs at the falling edge after that, before any input moves, so each result is read one edge after its cause and never on the edge itself.

// File: rtl/host_cmd_vec.sv
`timescale 1ns/1ps
module host_cmd_vec #(
  parameter int VEC_W = 7,
  parameter int PRI_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_W-1:0] cfg_vec_default,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  input  logic             hc_enable,
  input  logic [PRI_W-1:0] prog_pri,
  output logic             irq_req,
  output logic [VEC_W:0]   irq_addr,
  output logic             irq_nmi,
  output logic [PRI_W-1:0] irq_level,
  input  logic             irq_ack,
  output logic             vec_err
);
  localparam int NMI_BIT = 15;
  localparam logic [PRI_W-1:0] TOP_PRI = '1;

  logic [VEC_W-1:0] vec_q;
  logic             nmi_q, cmd_q, err_q;

  wire            host_wr = wr_en && !cmd_q;
  wire [VEC_W-1:0] wr_vec = wr_data[VEC_W:1];
  wire            bad_cmd = host_wr && wr_data[0] && (wr_vec == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= cfg_vec_default;
      nmi_q <= 1'b0;
      cmd_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      err_q <= bad_cmd;
      if (host_wr) begin
        vec_q <= wr_vec;
        nmi_q <= wr_data[NMI_BIT];
        cmd_q <= wr_data[0] && !bad_cmd;
      end else if (cmd_q && irq_ack) begin
        cmd_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[NMI_BIT] = nmi_q;
    rd_data[VEC_W:1] = vec_q;
    rd_data[0] = cmd_q;
  end

  assign irq_addr  = {vec_q, 1'b0};
  assign irq_req   = cmd_q && (nmi_q || hc_enable);
  assign irq_nmi   = cmd_q && nmi_q;
  assign irq_level = nmi_q ? TOP_PRI : prog_pri;
  assign vec_err   = err_q;

  p_hold_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[0] && !irq_ack) |=> (rd_data[0] && $stable(rd_data[NMI_BIT:1])));

  p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[0] && irq_ack) |=> !rd_data[0]);

  p_err_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_err |-> (!irq_req && !rd_data[0] && rd_data[VEC_W:1] == '0));

  p_nmi_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_nmi |-> (irq_req && irq_level == TOP_PRI));

  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[0] && !rd_data[NMI_BIT] && !hc_enable) |-> !irq_req);

  p_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_addr == {rd_data[VEC_W:1], 1'b0});
endmodule

// File: tb/sim_host_cmd_vec.sv
`timescale 1ns/1ps
module sim_host_cmd_vec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  cfg_vec_default = 7'h2A;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        hc_enable = 1'b0;
  logic [1:0]  prog_pri = 2'd0;
  logic        irq_req;
  logic [7:0]  irq_addr;
  logic        irq_nmi;
  logic [1:0]  irq_level;
  logic        irq_ack = 1'b0;
  logic        vec_err;

  int checks = 0;
  int errors = 0;
  logic [6:0] m_vec;
  logic       m_nmi, m_cmd, m_err;

  always #2 clk = ~clk;

  host_cmd_vec u0 (
    .clk(clk), .rst_n(rst_n), .cfg_vec_default(cfg_vec_default),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .hc_enable(hc_enable), .prog_pri(prog_pri), .irq_req(irq_req),
    .irq_addr(irq_addr), .irq_nmi(irq_nmi), .irq_level(irq_level),
    .irq_ack(irq_ack), .vec_err(vec_err));

  function automatic logic [31:0] exp_rd();
    return {16'h0, m_nmi, 7'h0, m_vec, m_cmd};
  endfunction
  function automatic logic exp_req();
    return m_cmd && (m_nmi || hc_enable);
  endfunction
  function automatic logic [1:0] exp_lvl();
    return m_nmi ? 2'd3 : prog_pri;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2 rd_data", rd_data, exp_rd());
    chk("R3 reserved", {rd_data[31:16], rd_data[14:8]}, '0);
    chk("R4 irq_addr", {24'h0, irq_addr}, {24'h0, m_vec, 1'b0});
    chk(m_nmi ? "R5 irq_req" : "R6 irq_req", {31'h0, irq_req}, {31'h0, exp_req()});
    chk(m_nmi ? "R5 irq_nmi" : "R6 irq_nmi", {31'h0, irq_nmi}, {31'h0, m_cmd && m_nmi});
    chk(m_nmi ? "R5 irq_level" : "R6 irq_level", {30'h0, irq_level}, {30'h0, exp_lvl()});
    chk("R7 vec_err", {31'h0, vec_err}, {31'h0, m_err});
  endtask

  task automatic step(logic we, logic [31:0] wd, logic ack, logic en, logic [1:0] pri);
    @(negedge clk);
    wr_en = we; wr_data = wd; irq_ack = ack; hc_enable = en; prog_pri = pri;
    @(posedge clk);
    m_err = 1'b0;
    if (!m_cmd && we) begin
      m_vec = wd[7:1];
      m_nmi = wd[15];
      if (wd[0]) begin
        if (wd[7:1] == 7'h0) m_err = 1'b1;
        else m_cmd = 1'b1;
      end
    end else if (m_cmd && ack) begin
      m_cmd = 1'b0;
    end
    @(negedge clk);
    check_all();
    wr_en = 1'b0; irq_ack = 1'b0;
  endtask

  task automatic do_reset(logic [6:0] dflt);
    @(negedge clk);
    rst_n = 1'b0; cfg_vec_default = dflt; wr_en = 1'b0; irq_ack = 1'b0;
    #1;
    m_vec = dflt; m_nmi = 1'b0; m_cmd = 1'b0; m_err = 1'b0;
    chk("R1 reset rd_data", rd_data, {25'h0, dflt, 1'b0});
    chk("R1 reset irq_req", {30'h0, irq_req, irq_nmi}, '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset rd_data", rd_data, {25'h0, dflt, 1'b0});
    chk("R1 after reset vec_err", {31'h0, vec_err}, '0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] wd;
    void'($urandom(32'd1234));
    do_reset(7'h2A);
    // R2 plain write without command
    step(1'b1, 32'h0000_8046, 1'b0, 1'b0, 2'd1);
    chk("R2 vector loaded", {25'h0, rd_data[7:1]}, 32'h23);
    // R3 all ones into reserved bits, command bit clear
    step(1'b1, 32'hFFFF_7FFE, 1'b0, 1'b0, 2'd0);
    chk("R3 reserved ignored", rd_data, 32'h0000_00FE);
    // R6 non-nmi command with enable low, then high
    step(1'b1, 32'h0000_0011, 1'b0, 1'b0, 2'd2);
    chk("R6 suppressed", {31'h0, irq_req}, '0);
    step(1'b0, '0, 1'b0, 1'b1, 2'd2);
    chk("R6 enabled level", {29'h0, irq_req, irq_level}, 32'h6);
    // R9 writes ignored while pending
    step(1'b1, 32'h0000_80FE, 1'b0, 1'b1, 2'd2);
    chk("R9 frozen", rd_data, 32'h0000_0011);
    // R8 ack clears
    step(1'b0, '0, 1'b1, 1'b1, 2'd2);
    chk("R8 cleared", {31'h0, rd_data[0]}, '0);
    // R5 nmi with enable low
    step(1'b1, 32'h0000_8003, 1'b0, 1'b0, 2'd0);
    chk("R5 nmi forced", {28'h0, irq_req, irq_nmi, irq_level}, 32'hF);
    step(1'b0, '0, 1'b1, 1'b0, 2'd0);
    // R7 zero vector command
    step(1'b1, 32'h0000_8001, 1'b0, 1'b1, 2'd1);
    chk("R7 err pulse", {30'h0, vec_err, rd_data[0]}, 32'h2);
    step(1'b0, '0, 1'b0, 1'b1, 2'd1);
    chk("R7 err one cycle", {31'h0, vec_err}, '0);
    // R8 boundary: vector 127, held across many cycles
    step(1'b1, 32'h0000_00FF, 1'b0, 1'b1, 2'd3);
    for (int i = 0; i < 5; i++) step(1'b0, '0, 1'b0, 1'b1, 2'd0);
    chk("R8 still pending", {24'h0, rd_data[0], irq_addr[7:1]}, 32'hFF);
    step(1'b0, '0, 1'b1, 1'b1, 2'd0);
    // random
    for (int i = 0; i < 600; i++) begin
      wd = $urandom();
      if (($urandom() % 6) == 0) wd[7:1] = 7'h0;
      step(($urandom() % 3) == 0, wd, ($urandom() % 5) == 0,
           1'($urandom()), 2'($urandom()));
    end
    // R1 reset with another default
    do_reset(7'h05);
    chk("R1 new default addr", {24'h0, irq_addr}, 32'h0A);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule